// File: doc/BRIEF.md
# Faithful Fixed-Point Times Real-Constant Multiplier

This block multiplies a fixed-point input by a real constant that is fixed at elaboration. The constant is never rounded to a fixed-point number first. The input word is cut into digits of a fixed bit count. Each digit addresses its own small constant table. Every table entry is the exact real product of the constant with that digit's weighted value, rounded to nearest at a precision a few guard bits finer than the output LSB. The table outputs are added, and the guard bits are then simply dropped.

One table also carries a half output ulp in every entry. Because of this, dropping the guard bits is a round to nearest of the sum. The number of guard bits grows with the digit count, so that all table roundings together stay below half an output ulp. The result is therefore faithful: it always lies within one output ulp of the true product.

The input format is given by its MSB and LSB positions and can be signed or unsigned. The output is always two's complement. The block is a two-stage pipeline: table reads are registered first, then the sum. It is meant for datapaths where a constant-coefficient product feeds further fixed-point arithmetic.

Top module: `kcm_const_mult`

## Requirements
- R1: The input is a WX = IN_MSB − IN_LSB + 1 bit word with LSB weight 2^IN_LSB. It is two's complement when IN_SIGNED = 1, so bit WX−1 weighs −2^IN_MSB, and plain binary otherwise. The output r_o is a two's complement word with LSB weight 2^OUT_LSB and width OUT_MSB − OUT_LSB + 1.
- R2: For every input value X, the output value R satisfies |R − C·X| < 2^OUT_LSB.
- R3: Whenever C·X is exactly representable in the output format, R equals C·X exactly.
- R4: A zero input gives a zero output.
- R5: The result for an input sampled at a rising clock edge appears on r_o after the second following rising edge. While the input is held, r_o does not change.
- R6: While rst_ni is low, r_o is zero after the next rising edge.
- R7: For C > 0, a positive input gives an output ≥ 0, and a negative input gives an output ≤ 0.
- R8: The input width need not be a multiple of DIGIT_W. The top digit then takes the leftover bits, and its value is signed when the input is signed. R2 and R3 still hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| x_i | input | IN_MSB−IN_LSB+1 | Fixed-point input operand |
| r_o | output | OUT_MSB−OUT_LSB+1 | Faithfully rounded product |

## Verification
A wrong table entry or a wrong table alignment shows on r_o exactly two cycles after any input whose digit hits that entry. Such a fault breaks the one-ulp error bound or the exact results for an exactly representable constant. A lost rounding half or a wrong guard-bit count biases every output by up to an ulp, so a full input sweep against a real-valued reference exposes it within one pass. A fault in the top digit's sign handling flips the sign relation for negative inputs, and the sign check catches it as soon as the first negative input reaches r_o.

// File: rtl/kcm_pkg.sv
package kcm_pkg;

    // number of digits for a word of w bits split into d-bit digits
    function automatic int kcm_num_digits(int w, int d);
        return (w + d - 1) / d;
    endfunction

    // smallest g with 2^g > n
    function automatic int kcm_guard_bits(int n);
        int g;
        g = 0;
        while ((1 << g) <= n) g++;
        return g;
    endfunction

    // real product c*dval*2^expo rounded to nearest, plus an integer offset
    function automatic longint kcm_entry(real c, int dval, int expo, longint offset);
        real v;
        v = c * real'(dval) * (2.0 ** expo);
        return longint'($floor(v + 0.5)) + offset;
    endfunction

endpackage

// File: rtl/kcm_digit_table.sv
module kcm_digit_table
    import kcm_pkg::*;
#(
    parameter int  IDX_W      = 4,
    parameter int  SUM_W      = 16,
    parameter real CONST_C    = 0.7853981633974483,
    parameter int  EXPO       = 0,
    parameter int  HALF       = 0,
    parameter bit  SIGNED_IDX = 1'b0
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [SUM_W-1:0] val_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [SUM_W-1:0] rom [DEPTH];

    for (genvar j = 0; j < DEPTH; j++) begin : g_ent
        localparam int     DVAL = (SIGNED_IDX && j >= DEPTH / 2) ? j - DEPTH : j;
        localparam longint ENT  = kcm_entry(CONST_C, DVAL, EXPO, longint'(HALF));
        assign rom[j] = ENT[SUM_W-1:0];
    end

    assign val_o = rom[idx_i];

endmodule

// File: rtl/kcm_adder.sv
module kcm_adder #(
    parameter int N    = 3,
    parameter int W    = 16,
    parameter int DROP = 2
) (
    input  logic [N-1:0][W-1:0] parts_i,
    output logic [W-DROP-1:0]   sum_o
);
    logic [W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < N; i++) begin
            acc = acc + parts_i[i];
        end
    end

    assign sum_o = acc[W-1:DROP];

endmodule

// File: rtl/kcm_const_mult.sv
module kcm_const_mult
    import kcm_pkg::*;
#(
    parameter real CONST_C   = 0.7853981633974483,
    parameter bit  IN_SIGNED = 1'b1,
    parameter int  IN_MSB    = 11,
    parameter int  IN_LSB    = 0,
    parameter int  OUT_MSB   = 11,
    parameter int  OUT_LSB   = -2,
    parameter int  DIGIT_W   = 4
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [IN_MSB-IN_LSB:0]     x_i,
    output logic [OUT_MSB-OUT_LSB:0]   r_o
);
    localparam int WX    = IN_MSB - IN_LSB + 1;
    localparam int WR    = OUT_MSB - OUT_LSB + 1;
    localparam int ND    = kcm_num_digits(WX, DIGIT_W);
    localparam int TOP_W = WX - DIGIT_W * (ND - 1);
    localparam int G     = kcm_guard_bits(ND);
    localparam int WS    = WR + G;

    typedef struct packed {
        logic [ND-1:0][WS-1:0] parts;
        logic [WR-1:0]         res;
    } kcm_state_t;

    kcm_state_t            st_d, st_q;
    logic [ND-1:0][WS-1:0] tab_val;
    logic [WR-1:0]         sum_trunc;

    for (genvar i = 0; i < ND; i++) begin : g_dig
        localparam int W    = (i == ND - 1) ? TOP_W : DIGIT_W;
        localparam int EXPO = DIGIT_W * i + IN_LSB - OUT_LSB + G;
        localparam int HALF = (i == 0) ? (1 << (G - 1)) : 0;
        logic [W-1:0] idx;
        assign idx = x_i[i*DIGIT_W +: W];
        kcm_digit_table #(
            .IDX_W     (W),
            .SUM_W     (WS),
            .CONST_C   (CONST_C),
            .EXPO      (EXPO),
            .HALF      (HALF),
            .SIGNED_IDX(IN_SIGNED && (i == ND - 1))
        ) u_tab (
            .idx_i(idx),
            .val_o(tab_val[i])
        );
    end

    kcm_adder #(
        .N   (ND),
        .W   (WS),
        .DROP(G)
    ) u_add (
        .parts_i(st_q.parts),
        .sum_o  (sum_trunc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.parts = tab_val;
        st_d.res   = sum_trunc;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign r_o = st_q.res;

endmodule

// File: rtl/kcm_checker.sv
module kcm_checker #(
    parameter real CONST_C   = 0.7853981633974483,
    parameter bit  IN_SIGNED = 1'b1,
    parameter int  WX        = 12,
    parameter int  WR        = 14
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [WX-1:0] x_i,
    input logic [WR-1:0] r_o
);
    logic [2:0] run_cnt;
    logic       warm;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            run_cnt <= '0;
        end else if (run_cnt != 3'd4) begin
            run_cnt <= run_cnt + 3'd1;
        end
    end

    assign warm = (run_cnt == 3'd4);

    // R6
    p_reset_clears_r6: assert property (@(posedge clk_i)
        !rst_ni |=> (r_o == '0));

    // R4
    p_zero_in_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (warm && $past(x_i, 2) == '0) |-> (r_o == '0));

    // R5
    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (warm && $past(x_i, 2) == $past(x_i, 3)) |-> $stable(r_o));

    if (CONST_C > 0.0) begin : g_sign
        if (IN_SIGNED) begin : g_s
            // R7
            p_pos_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (warm && $signed($past(x_i, 2)) > 0) |-> !r_o[WR-1]);
            p_neg_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (warm && $signed($past(x_i, 2)) < 0) |-> (r_o[WR-1] || r_o == '0));
        end else begin : g_u
            p_pos_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                warm |-> !r_o[WR-1]);
        end
    end

endmodule

bind kcm_const_mult kcm_checker #(
    .CONST_C  (CONST_C),
    .IN_SIGNED(IN_SIGNED),
    .WX       (IN_MSB - IN_LSB + 1),
    .WR       (OUT_MSB - OUT_LSB + 1)
) u_chk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .x_i   (x_i),
    .r_o   (r_o)
);

// File: tb/tb_kcm_const_mult.sv
module tb_kcm_const_mult;

    localparam real CA = 0.7853981633974483;   // pi/4
    localparam real CB = 1.5;
    localparam real CC = 0.6931471805599453;   // ln 2

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [11:0] xa;
    logic [13:0] ra;
    logic [9:0]  xb;
    logic [11:0] rb;
    logic [7:0]  xc;
    logic [13:0] rc;

    // A: signed 12-bit integer input, out LSB 2^-2, 3 digits of 4
    kcm_const_mult #(.CONST_C(CA), .IN_SIGNED(1'b1), .IN_MSB(11), .IN_LSB(0),
        .OUT_MSB(11), .OUT_LSB(-2), .DIGIT_W(4)) dut (
        .clk_i(clk), .rst_ni(rst_n), .x_i(xa), .r_o(ra));
    // B: exact constant, signed 10-bit input LSB 2^-5, top digit 2 bits
    kcm_const_mult #(.CONST_C(CB), .IN_SIGNED(1'b1), .IN_MSB(4), .IN_LSB(-5),
        .OUT_MSB(5), .OUT_LSB(-6), .DIGIT_W(4)) dut_b (
        .clk_i(clk), .rst_ni(rst_n), .x_i(xb), .r_o(rb));
    // C: unsigned 8-bit input, digits of 3, top digit 2 bits
    kcm_const_mult #(.CONST_C(CC), .IN_SIGNED(1'b0), .IN_MSB(7), .IN_LSB(0),
        .OUT_MSB(8), .OUT_LSB(-5), .DIGIT_W(3)) dut_c (
        .clk_i(clk), .rst_ni(rst_n), .x_i(xc), .r_o(rc));

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic chk_int(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_bound(string req, real act, real exact, real ulp);
        real d;
        checks++;
        d = act - exact;
        if (d < 0.0) d = -d;
        if (!(d < ulp)) begin
            fails++;
            $display("FAIL %s actual=%f expected=%f (within %f)", req, act, exact, ulp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
            $finish;
        end
    end

    initial begin
        // R6: nonzero inputs while held in reset
        xa = 12'hABC; xb = 10'h2F3; xc = 8'hC7;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_int("R6 dut", longint'(ra), 0);
        chk_int("R6 dut_b", longint'(rb), 0);
        chk_int("R6 dut_c", longint'(rc), 0);
        rst_n = 1'b1;

        // full sweep: R1, R2, R3, R4, R7, R8
        for (int k = 0; k < 4096; k++) begin
            int  sa, sb, uc;
            real fa, fc;
            xa = k[11:0]; xb = k[9:0]; xc = k[7:0];
            @(posedge clk); @(posedge clk); @(negedge clk);
            sa = int'($signed(xa));
            sb = int'($signed(xb));
            uc = int'(xc);
            fa = real'($signed(ra)) * 0.25;
            fc = real'($signed(rc)) / 32.0;
            chk_bound("R2 dut pi/4", fa, CA * real'(sa), 0.25);
            if (k < 1024) begin
                // R3/R8: 1.5 * sb * 2^-5 = 3*sb units of 2^-6
                chk_int("R3 R8 dut_b exact", longint'($signed(rb)), longint'(3 * sb));
            end
            if (k < 256) begin
                chk_bound("R2 R8 dut_c ln2", fc, CC * real'(uc), 1.0 / 32.0);
            end
            if (sa > 0) chk_int("R7 dut positive sign", longint'(ra[13]), 0);
            if (sa < 0 && ra != '0) chk_int("R7 dut negative sign", longint'(ra[13]), 1);
            if (k == 0) begin
                chk_int("R4 dut zero", longint'(ra), 0);
                chk_int("R4 dut_c zero", longint'(rc), 0);
            end
        end

        // R1 extremes of the signed input range
        xa = 12'h800; xb = 10'h200;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk_bound("R1 dut most negative", real'($signed(ra)) * 0.25, CA * -2048.0, 0.25);
        chk_int("R1 dut_b most negative", longint'($signed(rb)), -1536);

        // R5: latency two edges, output held while input held
        xa = 12'd100;
        @(posedge clk); @(posedge clk); @(negedge clk);
        begin
            logic [13:0] held;
            held = ra;
            xa = 12'd1000;
            @(posedge clk); @(negedge clk);
            chk_int("R5 no change after one edge", longint'(ra), longint'(held));
            @(posedge clk); @(negedge clk);
            chk_bound("R5 result after two edges", real'($signed(ra)) * 0.25, CA * 1000.0, 0.25);
            held = ra;
            for (int n = 0; n < 5; n++) begin
                @(posedge clk); @(negedge clk);
                chk_int("R5 held input stable output", longint'(ra), longint'(held));
            end
        end

        // R6 again mid-run
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk_int("R6 mid-run reset", longint'(ra), 0);
        rst_n = 1'b1;

        done = 1'b1;
        report();
        $finish;
    end

endmodule